// File: doc/BRIEF.md
# I2C Bus-Clock Timing Generator

This block produces the bus-clock timing for an I2C master. A single 9-bit clock-control word selects two things. The first is a prescale divisor, which turns the system clock into a slower internal tick. The second is a gap count, which stretches the bus-clock period in steps of eight ticks. Each period lasts a base of 20 ticks, plus eight ticks per gap step, plus a fixed allowance `F_ALLOW`. That allowance covers the rise time, the fall time and the internal delay, rounded up to whole ticks. It is a synthesis parameter, so only the two register fields can move the period at run time. The prescale should be chosen so that the tick stays below 20 MHz.

Each period splits into a low half and a high half, and the high half gets the odd tick. The block drives the bus-clock level and gives one-cycle strobes at four points: both edges, the middle of the low half (the safe point to change SDA) and the middle of the high half (the point to sample SDA). During the high half the tick counter stops while the sensed bus clock is low, so a slave can stretch the clock.

A register write goes into a pending copy. That copy becomes the active setting only at the start of the next period, so a period already running is never distorted. Dropping the enable returns the clock to idle-high at once. Raising it starts a new period on the next clock edge.

Top module: `scl_timing_gen`

## Requirements
- R1: During and right after reset, `scl_out` is 1, all four strobes are 0 and `active_cfg` is 0.
- R2: A `cfg_wr` pulse stores `cfg_wdata` as the pending word. Bits [2:0] are the prescale value D and bits [8:3] are the gap value G. `active_cfg` shows the word in force.
- R3: With prescale D, the internal tick occurs once every D+1 clocks. Every phase length is a multiple of D+1 clocks.
- R4: A period lasts P = 20 + 8·G + F_ALLOW ticks.
- R5: The low phase lasts floor(P/2) ticks and the high phase lasts P − floor(P/2) ticks, when there is no stretching.
- R6: `sda_change` pulses for one clock in the low phase, floor(L/2)·(D+1) clocks after the `scl_fall` pulse, where L is the low length in ticks.
- R7: `sda_sample` pulses for one clock in the high phase, floor(H/2)·(D+1) clocks after the `scl_rise` pulse (no stretching), where H is the high length in ticks.
- R8: In the high phase, a tick that sees `scl_sense` low does not advance the phase. With D=0, holding `scl_sense` low for N clocks after the rise lengthens the high phase, and delays `sda_sample`, by N clocks.
- R9: A written word reaches `active_cfg` and the timing only at the next period start (a `scl_fall` pulse). A word written while disabled, or mid-period, leaves the current timing unchanged.
- R10: While `en` is 0, `scl_out` is 1 and no strobe pulses. In the first clock after `en` is sampled 1, `scl_fall` is 1 and `scl_out` is 0.
- R11: At most one of the four strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the clock-control word |
| cfg_wdata | input | 9 | Clock-control word: [2:0] prescale, [8:3] gap |
| en | input | 1 | Run the bus clock; 0 holds it idle high |
| scl_sense | input | 1 | Sensed level of the bus-clock line |
| active_cfg | output | 9 | Clock-control word currently in force |
| scl_out | output | 1 | Bus-clock level to drive (1 = released) |
| scl_fall | output | 1 | One-clock pulse: period start, clock went low |
| scl_rise | output | 1 | One-clock pulse: clock released high |
| sda_change | output | 1 | One-clock pulse: middle of low phase |
| sda_sample | output | 1 | One-clock pulse: middle of high phase |

## Verification
The assertions assume that `scl_sense` reflects the driven level, apart from stretches that start only after a rise. They also assume that `en` and `cfg_wr` are stable, synchronous inputs. The bench follows this. It derives `scl_sense` from `scl_out`, and pulls it low only in the clocks that follow an `scl_rise` pulse. It changes `en` and `cfg_wdata` just after a rising edge. It applies stretching only with prescale 0, where a held clock maps one-to-one onto a held tick.

// File: rtl/scl_pkg.sv
// Package: shared field widths and the clock-control word layout.
// Assumes the register is 9 bits: prescale in the low bits, gap above it.
package scl_pkg;
    localparam int CDF_W = 3;
    localparam int GAP_W = 6;
    localparam int CFG_W = CDF_W + GAP_W;

    typedef struct packed {
        logic [GAP_W-1:0] gap;
        logic [CDF_W-1:0] div;
    } clk_cfg_t;
endpackage

// File: rtl/scl_cfg_reg.sv
// Module: double-buffered clock-control word.
// A write lands in the pending copy; the active copy follows only on load,
// which the phase counter raises at each period start.
module scl_cfg_reg
    import scl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  clk_cfg_t wdata,
    input  logic     load,
    output clk_cfg_t act
);
    clk_cfg_t pend;

    // capture software writes into the pending copy
    always_ff @(posedge clk) begin
        if (!rst_n)  pend <= '0;
        else if (wr) pend <= wdata;
    end

    // move the pending word into force at a period boundary
    always_ff @(posedge clk) begin
        if (!rst_n)    act <= '0;
        else if (load) act <= pend;
    end
endmodule

// File: rtl/scl_prescaler.sv
// Module: internal tick generator, one tick per (div+1) clocks.
// Assumes run drops for at least one clock whenever the period
// sequence restarts from idle, so the count starts from zero.
module scl_prescaler
    import scl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CDF_W-1:0] div,
    output logic             tick
);
    logic [CDF_W-1:0] pre_cnt;

    assign tick = run && (pre_cnt == div);

    // count clocks modulo div+1 while running
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pre_cnt <= '0;
        else if (tick)      pre_cnt <= '0;
        else                pre_cnt <= pre_cnt + 1'b1;
    end

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || div == '0));
endmodule

// File: rtl/scl_phase_ctr.sv
// Module: bus-clock phase sequencer.
// Counts ticks through a low phase then a high phase whose lengths come
// from the active gap field; holds in the high phase while the line is
// sensed low. Emits registered one-clock strobes at edges and midpoints.
module scl_phase_ctr
    import scl_pkg::*;
#(
    parameter int BASE_TICKS = 20,
    parameter int GAP_STEP   = 8,
    parameter int F_ALLOW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             scl_sense,
    input  logic [GAP_W-1:0] gap,
    output logic             running,
    output logic             period_start,
    output logic             scl_out,
    output logic             fall_p,
    output logic             rise_p,
    output logic             chg_p,
    output logic             smp_p
);
    localparam int P_MAX = BASE_TICKS + GAP_STEP * ((1 << GAP_W) - 1) + F_ALLOW;
    localparam int CNT_W = $clog2(P_MAX + 1);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             idle;
    logic             phase_hi;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] period, lo_len, hi_len, lo_mid, hi_mid;
    logic             lo_step, lo_last, hi_adv, hi_last;

    assign running = !idle;
    assign scl_out = phase_hi;

    // derive phase lengths and midpoints from the active gap
    always_comb begin
        period = CNT_W'(BASE_TICKS) + CNT_W'(GAP_STEP) * CNT_W'(gap) + CNT_W'(F_ALLOW);
        lo_len = period >> 1;
        hi_len = period - lo_len;
        lo_mid = lo_len >> 1;
        hi_mid = hi_len >> 1;
    end

    // decode the events of this tick
    always_comb begin
        lo_step      = en && tick && !idle && !phase_hi;
        lo_last      = lo_step && (cnt == lo_len - ONE);
        hi_adv       = en && tick && !idle && phase_hi && scl_sense;
        hi_last      = hi_adv && (cnt == hi_len - ONE);
        period_start = en && (idle || hi_last);
    end

    // sequence phases, count ticks and register the strobes
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            idle     <= 1'b1;
            phase_hi <= 1'b1;
            cnt      <= '0;
            fall_p   <= 1'b0;
            rise_p   <= 1'b0;
            chg_p    <= 1'b0;
            smp_p    <= 1'b0;
        end else begin
            fall_p <= 1'b0;
            rise_p <= 1'b0;
            chg_p  <= 1'b0;
            smp_p  <= 1'b0;
            if (period_start) begin
                idle     <= 1'b0;
                phase_hi <= 1'b0;
                cnt      <= '0;
                fall_p   <= 1'b1;
            end else if (lo_last) begin
                phase_hi <= 1'b1;
                cnt      <= '0;
                rise_p   <= 1'b1;
            end else if (lo_step) begin
                cnt   <= cnt + ONE;
                chg_p <= (cnt == lo_mid - ONE);
            end else if (hi_adv) begin
                cnt   <= cnt + ONE;
                smp_p <= (cnt == hi_mid - ONE);
            end
        end
    end

    // R8
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !idle && phase_hi && !scl_sense) |=> (phase_hi && $stable(cnt)));

    // R5
    low_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !idle && !phase_hi && cnt == lo_len - ONE) |=> (rise_p && scl_out));

    // R5
    low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_hi) |-> (cnt < lo_len));
endmodule

// File: rtl/scl_timing_gen.sv
// Module: top of the bus-clock timing generator.
// Ties the double-buffered control word, the tick prescaler and the
// phase sequencer together. Assumes scl_sense is already synchronised.
module scl_timing_gen
    import scl_pkg::*;
#(
    parameter int BASE_TICKS = 20,
    parameter int GAP_STEP   = 8,
    parameter int F_ALLOW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             en,
    input  logic             scl_sense,
    output logic [CFG_W-1:0] active_cfg,
    output logic             scl_out,
    output logic             scl_fall,
    output logic             scl_rise,
    output logic             sda_change,
    output logic             sda_sample
);
    clk_cfg_t act;
    logic     tick, running, period_start;

    assign active_cfg = act;

    scl_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (clk_cfg_t'(cfg_wdata)),
        .load  (period_start),
        .act   (act)
    );

    scl_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en && running),
        .div   (act.div),
        .tick  (tick)
    );

    scl_phase_ctr #(
        .BASE_TICKS (BASE_TICKS),
        .GAP_STEP   (GAP_STEP),
        .F_ALLOW    (F_ALLOW)
    ) u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .tick         (tick),
        .scl_sense    (scl_sense),
        .gap          (act.gap),
        .running      (running),
        .period_start (period_start),
        .scl_out      (scl_out),
        .fall_p       (scl_fall),
        .rise_p       (scl_rise),
        .chg_p        (sda_change),
        .smp_p        (sda_sample)
    );

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_fall, scl_rise, sda_change, sda_sample}));

    // R10
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (scl_out && !scl_fall && !sda_change && !sda_sample));

    // R9
    cfg_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act) |-> scl_fall);
endmodule

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;
    localparam int F_ALLOW = 5;

    typedef struct {
        int lo;
        int hi;
        int chg;
        int smp;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [8:0] cfg_wdata = '0;
    logic       en = 1'b0;
    logic       stretch = 1'b0;
    logic       scl_sense;
    logic [8:0] active_cfg;
    logic       scl_out, scl_fall, scl_rise, sda_change, sda_sample;

    int   n_chk = 0;
    int   n_bad = 0;
    int   stretch_n = 0;
    exp_t exp_q[$];

    assign scl_sense = scl_out & ~stretch;

    always #10 clk = ~clk;

    scl_timing_gen #(.F_ALLOW(F_ALLOW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .en         (en),
        .scl_sense  (scl_sense),
        .active_cfg (active_cfg),
        .scl_out    (scl_out),
        .scl_fall   (scl_fall),
        .scl_rise   (scl_rise),
        .sda_change (sda_change),
        .sda_sample (sda_sample)
    );

    task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
        end
    endtask

    function automatic exp_t make_exp(input int d, input int g, input int s);
        exp_t e;
        int p, l, h, k;
        p = 20 + 8 * g + F_ALLOW;   // R4
        l = p / 2;                  // R5
        h = p - l;
        k = d + 1;                  // R3
        e.lo  = l * k;
        e.hi  = h * k + s;          // R8
        e.chg = (l / 2) * k;        // R6
        e.smp = (h / 2) * k + s;    // R7
        return e;
    endfunction

    // monitor: measure each full period and compare with the scoreboard
    int   run_cnt = 0, lo_m = 0, chg_m = -1, smp_m = -1;
    bit   in_per = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_change) chg_m = run_cnt;
            if (sda_sample) smp_m = run_cnt;
            if (scl_fall) begin
                if (in_per) begin
                    exp_t e;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R4 unexpected period", run_cnt, 0);
                    end else begin
                        e = exp_q.pop_front();
                        check(lo_m == e.lo, "R5 low length", lo_m, e.lo);
                        check(run_cnt == e.hi, "R5/R8 high length", run_cnt, e.hi);
                        check(chg_m == e.chg, "R6 sda_change offset", chg_m, e.chg);
                        check(smp_m == e.smp, "R7 sda_sample offset", smp_m, e.smp);
                    end
                end
                in_per  = 1'b1;
                run_cnt = 1;
                chg_m   = -1;
            end else if (scl_rise) begin
                lo_m    = run_cnt;
                run_cnt = 1;
                smp_m   = -1;
            end else if (in_per) begin
                run_cnt++;
            end
            if (!en) in_per = 1'b0;
        end
    end

    // slave model: hold the clock low for stretch_n clocks after a rise
    always @(negedge clk) begin
        if (scl_rise && stretch_n > 0) begin
            stretch = 1'b1;
            repeat (stretch_n) @(negedge clk);
            stretch   = 1'b0;
            stretch_n = 0;
        end
    end

    task automatic wr_cfg(input int d, input int g);
        @(posedge clk); #2;
        cfg_wdata = {g[5:0], d[2:0]};
        cfg_wr    = 1'b1;
        @(posedge clk); #2;
        cfg_wr    = 1'b0;
    endtask

    task automatic wait_falls(input int n);
        int seen = 0;
        while (seen < n) begin
            @(negedge clk);
            if (scl_fall) seen++;
        end
    endtask

    task automatic start_run(input int word);
        @(posedge clk); #2;
        en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R10
        check(scl_fall && !scl_out, "R10 start fall", {scl_fall, scl_out}, 2);
        // R2
        check(active_cfg == word[8:0], "R2 active word", active_cfg, word);
    endtask

    task automatic stop_run();
        @(posedge clk); #2;
        en = 1'b0;
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4 periods consumed", exp_q.size(), 0);
    endtask

    task automatic run_cfg(input int d, input int g, input int n, input int s);
        wr_cfg(d, g);
        for (int i = 0; i < n; i++) exp_q.push_back(make_exp(d, g, (i == 0) ? s : 0));
        stretch_n = s;
        start_run(g * 8 + d);
        wait_falls(n);
        stop_run();
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        check(scl_out == 1'b1, "R1 reset scl", scl_out, 1);
        check({scl_fall, scl_rise, sda_change, sda_sample} == 4'b0, "R1 reset strobes",
              {scl_fall, scl_rise, sda_change, sda_sample}, 0);
        check(active_cfg == 9'd0, "R1 reset word", active_cfg, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;

        // R9: a write while disabled does not reach the active word
        wr_cfg(3, 9);
        repeat (4) @(negedge clk);
        check(active_cfg == 9'd0, "R9 write while idle", active_cfg, 0);

        // R10: disabled, no strobes and clock high
        begin
            int pulses = 0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (scl_fall | scl_rise | sda_change | sda_sample | !scl_out) pulses++;
            end
            check(pulses == 0, "R10 idle quiet", pulses, 0);
        end

        // R3 R4 R5 R6 R7: several settings
        run_cfg(0, 0, 3, 0);
        run_cfg(2, 1, 2, 0);
        run_cfg(7, 63, 2, 0);
        run_cfg(5, 10, 2, 0);

        // R8: stretch by a slave at prescale 0
        run_cfg(0, 3, 2, 4);

        // R9: mid-period change takes effect at next period
        wr_cfg(1, 2);
        exp_q.push_back(make_exp(1, 2, 0));
        exp_q.push_back(make_exp(0, 5, 0));
        start_run(2 * 8 + 1);
        repeat (5) @(negedge clk);
        wr_cfg(0, 5);
        @(negedge clk);
        check(active_cfg == 9'(2 * 8 + 1), "R9 held mid-period", active_cfg, 17);
        wait_falls(1);
        check(active_cfg == 9'(5 * 8), "R9 applied at fall", active_cfg, 40);
        wait_falls(1);
        stop_run();

        // R10: after disable the clock returns high and stays quiet
        begin
            int pulses = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (scl_fall | scl_rise | sda_change | sda_sample | !scl_out) pulses++;
            end
            check(pulses == 0, "R10 quiet after stop", pulses, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule